// File: doc/BRIEF.md
# Secondary-Clock Idle Power Controller

This block sequences the power modes of a small microcontroller around a slow secondary oscillator. From primary run, a sleep request from the CPU is accepted only when the idle-enable bit is set, the clock-select field selects the secondary source and the secondary oscillator is enabled. After a one-cycle clock handover the CPU clock is stopped, the peripherals run from the secondary oscillator and the primary oscillator is powered down. If the secondary oscillator is enabled but has not started, the peripheral clock enable is held off until it reports running.

A wake event brings the part back in two stages. The primary oscillator is powered up at once. The CPU resumes on the secondary clock after a fixed wake delay. The controller then waits until the primary oscillator has produced its start-up count of periods, plus a PLL lock interval when the PLL is selected, and only then makes a second one-cycle handover back to the primary clock. Two status outputs report whether the primary clock has completed start-up and is in use, and whether the secondary clock is the active source.

Every clock is modelled as an enable in one reference clock domain. The delays are parameters counted in reference cycles, and primary oscillator periods arrive as a tick input.

Top module: `secclk_pwr_ctrl`

## Requirements
- R1: A sleep request moves the controller from primary run only when idle_en is 1, clk_sel is 2'b01 (the secondary source) and sec_osc_en is 1. The cycle after the request edge is a handover cycle, and the idle state follows one cycle later. A request with idle_en at 0 or with clk_sel not equal to 2'b01 leaves primary run unchanged.
- R2: A sleep request that arrives with sec_osc_en at 0 is a no-op: the outputs stay in primary run.
- R3: In idle, cpu_clk_en is 0, per_src_sec is 1 (secondary source), pri_osc_pwr is 0, sec_active is 1 and pri_ok is 0. Idle lasts until a wake event.
- R4: While the peripherals are on the secondary source, per_clk_en (and cpu_clk_en in secondary run) is 1 only while sec_osc_run is 1.
- R5: A wake event sampled in idle powers the primary oscillator from the next cycle. The CPU stays stopped for exactly WAKE_CYC cycles and then runs on the secondary clock (cpu_clk_en 1, per_src_sec 1).
- R6: The primary clock counts as ready only after OST_TICKS pri_tick pulses have been seen while it is powered. When pll_sel is 1, a further PLL_CYC reference cycles must also pass. Until then the controller stays in secondary run.
- R7: The cycle after readiness is sampled in secondary run is a handover cycle. After it comes primary run, with pri_ok 1, sec_active 0, cpu_clk_en 1, per_src_sec 0 and pri_osc_pwr 1.
- R8: In each handover cycle cpu_clk_en, per_clk_en, pri_ok and sec_active are all 0. per_src_sec changes only in a cycle where both clock enables are 0.
- R9: A wake event that arrives during the entry handover cycle is held. Idle then lasts one cycle and the wake delay starts without a further wake event.
- R10: After reset the controller is in primary run with pri_ok 1 and the primary clock counted as started.
- R11: A wake event in primary run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle sleep request from the CPU |
| idle_en | input | 1 | Idle-enable mode bit |
| clk_sel | input | 2 | Clock-select field (2'b01 selects secondary) |
| sec_osc_en | input | 1 | Secondary oscillator enable |
| sec_osc_run | input | 1 | Secondary oscillator is running |
| pri_tick | input | 1 | One pulse per primary oscillator period |
| pll_sel | input | 1 | PLL lock wait is required |
| wake_evt | input | 1 | Wake event |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| per_src_sec | output | 1 | Peripheral/system clock source: 1 secondary, 0 primary |
| pri_osc_pwr | output | 1 | Primary oscillator power enable |
| pri_ok | output | 1 | Status: primary start-up complete and in use |
| sec_active | output | 1 | Status: secondary clock is the active source |

## Verification
All outputs are decoded from the state register. The bench drives and samples on the falling edge, so each result is due a whole number of rising edges after its stimulus. The handover shows one edge after an accepted request, idle after two, and the wake-wait state one edge after a sampled wake. Secondary run begins WAKE_CYC edges later. The return handover comes OST_TICKS+1 edges after the wake when pri_tick is steady and no PLL is used (plus PLL_CYC with it), and primary run follows one edge after that. The bench checks the cycle just before each of these transitions as well as the cycle of the transition, so an early or a late change is reported. With sparse ticks, where only bounds are known, it checks one point well before readiness and one point safely after it.

// File: rtl/secclk_pkg.sv
package secclk_pkg;

  typedef enum logic [2:0] {
    PM_RUN_PRI,
    PM_ENTER,
    PM_IDLE_SEC,
    PM_WAKE_WAIT,
    PM_RUN_SEC,
    PM_RETURN
  } pm_state_t;

  localparam logic [1:0] SEL_SECONDARY = 2'b01;

  typedef struct packed {
    logic cpu_en;
    logic src_sec;
    logic per_en;
    logic pri_pwr;
    logic pri_ok;
    logic sec_act;
  } pm_out_t;

  function automatic logic idle_entry_ok(input logic sleep, input logic idle_en,
                                         input logic [1:0] sel, input logic sec_en);
    return sleep & idle_en & (sel == SEL_SECONDARY) & sec_en;
  endfunction

  function automatic logic primary_ready(input logic ost_done, input logic pll_sel,
                                         input logic pll_done);
    return ost_done & (~pll_sel | pll_done);
  endfunction

  function automatic pm_out_t decode_state(input pm_state_t st);
    pm_out_t o;
    o = '0;
    case (st)
      PM_RUN_PRI:   begin o.cpu_en = 1'b1; o.per_en = 1'b1; o.pri_pwr = 1'b1; o.pri_ok = 1'b1; end
      PM_ENTER:     begin o.src_sec = 1'b1; o.pri_pwr = 1'b1; end
      PM_IDLE_SEC:  begin o.src_sec = 1'b1; o.per_en = 1'b1; o.sec_act = 1'b1; end
      PM_WAKE_WAIT: begin o.src_sec = 1'b1; o.per_en = 1'b1; o.pri_pwr = 1'b1; o.sec_act = 1'b1; end
      PM_RUN_SEC:   begin o.cpu_en = 1'b1; o.src_sec = 1'b1; o.per_en = 1'b1;
                          o.pri_pwr = 1'b1; o.sec_act = 1'b1; end
      PM_RETURN:    begin o.pri_pwr = 1'b1; end
      default:      o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/secclk_wake_timer.sv
module secclk_wake_timer #(
  parameter int CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (done)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/secclk_pri_ready.sv
module secclk_pri_ready
  import secclk_pkg::*;
#(
  parameter int OST_TICKS = 1024,
  parameter int PLL_CYC   = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr,
  input  logic tick,
  input  logic pll_sel,
  output logic ready
);
  localparam int OW = $clog2(OST_TICKS + 1);
  localparam int PW = $clog2(PLL_CYC + 1);
  localparam logic [OW-1:0] OST_FULL = OW'(OST_TICKS);
  localparam logic [PW-1:0] PLL_FULL = PW'(PLL_CYC);

  logic [OW-1:0] ost_cnt;
  logic [PW-1:0] pll_cnt;
  logic          ost_done;
  logic          pll_done;

  assign ost_done = (ost_cnt == OST_FULL);
  assign pll_done = (pll_cnt == PLL_FULL);
  assign ready    = primary_ready(ost_done, pll_sel, pll_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ost_cnt <= OST_FULL;
      pll_cnt <= PLL_FULL;
    end else if (!pwr) begin
      ost_cnt <= '0;
      pll_cnt <= '0;
    end else begin
      if (tick && !ost_done)                ost_cnt <= ost_cnt + 1'b1;
      if (ost_done && pll_sel && !pll_done) pll_cnt <= pll_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/secclk_mode_fsm.sv
module secclk_mode_fsm
  import secclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      entry_ok,
  input  logic      wake_evt,
  input  logic      dly_done,
  input  logic      pri_ready,
  output pm_state_t state,
  output logic      wake_seen
);
  pm_state_t nxt;
  logic      wake_pend;

  assign wake_seen = wake_evt | wake_pend;

  always_comb begin
    nxt = state;
    case (state)
      PM_RUN_PRI:   if (entry_ok)  nxt = PM_ENTER;
      PM_ENTER:                    nxt = PM_IDLE_SEC;
      PM_IDLE_SEC:  if (wake_seen) nxt = PM_WAKE_WAIT;
      PM_WAKE_WAIT: if (dly_done)  nxt = PM_RUN_SEC;
      PM_RUN_SEC:   if (pri_ready) nxt = PM_RETURN;
      PM_RETURN:                   nxt = PM_RUN_PRI;
      default:                     nxt = PM_RUN_PRI;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PM_RUN_PRI;
      wake_pend <= 1'b0;
    end else begin
      state <= nxt;
      if (state == PM_ENTER && wake_evt) wake_pend <= 1'b1;
      else if (state == PM_IDLE_SEC)     wake_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/secclk_pwr_ctrl.sv
module secclk_pwr_ctrl
  import secclk_pkg::*;
#(
  parameter int WAKE_CYC  = 10,
  parameter int OST_TICKS = 1024,
  parameter int PLL_CYC   = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       idle_en,
  input  logic [1:0] clk_sel,
  input  logic       sec_osc_en,
  input  logic       sec_osc_run,
  input  logic       pri_tick,
  input  logic       pll_sel,
  input  logic       wake_evt,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       per_src_sec,
  output logic       pri_osc_pwr,
  output logic       pri_ok,
  output logic       sec_active
);
  pm_state_t state;
  pm_out_t   dec;
  logic      entry_ok;
  logic      dly_done;
  logic      pri_ready;
  logic      wake_seen;
  logic      src_gate;

  assign entry_ok = idle_entry_ok(sleep_req, idle_en, clk_sel, sec_osc_en);

  secclk_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .entry_ok  (entry_ok),
    .wake_evt  (wake_evt),
    .dly_done  (dly_done),
    .pri_ready (pri_ready),
    .state     (state),
    .wake_seen (wake_seen)
  );

  secclk_wake_timer #(.CYC(WAKE_CYC)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == PM_WAKE_WAIT),
    .done  (dly_done)
  );

  assign dec = decode_state(state);

  secclk_pri_ready #(.OST_TICKS(OST_TICKS), .PLL_CYC(PLL_CYC)) u_pri (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr     (dec.pri_pwr),
    .tick    (pri_tick),
    .pll_sel (pll_sel),
    .ready   (pri_ready)
  );

  assign src_gate    = dec.src_sec ? sec_osc_run : 1'b1;
  assign cpu_clk_en  = dec.cpu_en & src_gate;
  assign per_clk_en  = dec.per_en & src_gate;
  assign per_src_sec = dec.src_sec;
  assign pri_osc_pwr = dec.pri_pwr;
  assign pri_ok      = dec.pri_ok;
  assign sec_active  = dec.sec_act;
endmodule

// File: rtl/secclk_pwr_ctrl_chk.sv
module secclk_pwr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_req,
  input logic sec_osc_en,
  input logic sec_osc_run,
  input logic cpu_clk_en,
  input logic per_clk_en,
  input logic per_src_sec,
  input logic pri_osc_pwr,
  input logic pri_ok,
  input logic sec_active,
  input logic pri_ready
);
  a_r1_entry_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_src_sec) |-> $past(sleep_req));

  a_r2_no_entry_without_osc: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !sec_osc_en && pri_ok) |=> pri_ok);

  a_r3_idle_entry_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_active) |-> (!pri_osc_pwr && !cpu_clk_en && per_src_sec && !pri_ok));

  a_r4_sec_gated_by_run: assert property (@(posedge clk) disable iff (!rst_n)
    (per_src_sec && (per_clk_en || cpu_clk_en)) |-> sec_osc_run);

  a_r5_pri_power_before_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pri_osc_pwr) |-> (!cpu_clk_en && sec_active));

  a_r6_return_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pri_ok) |-> $past(pri_ready));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_ok && sec_active));

  a_r8_switch_while_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_src_sec) |-> (!per_clk_en && !cpu_clk_en));
endmodule

bind secclk_pwr_ctrl secclk_pwr_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_req   (sleep_req),
  .sec_osc_en  (sec_osc_en),
  .sec_osc_run (sec_osc_run),
  .cpu_clk_en  (cpu_clk_en),
  .per_clk_en  (per_clk_en),
  .per_src_sec (per_src_sec),
  .pri_osc_pwr (pri_osc_pwr),
  .pri_ok      (pri_ok),
  .sec_active  (sec_active),
  .pri_ready   (pri_ready)
);

// File: tb/tb_secclk_pwr_ctrl.sv
module tb_secclk_pwr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;
  localparam int N = 32;
  localparam int P = 20;

  // expected output vectors {cpu, src_sec, per, pri_pwr, pri_ok, sec_act}
  localparam logic [5:0] V_RUN_PRI  = 6'b101110;
  localparam logic [5:0] V_HANDOVER = 6'b010100;
  localparam logic [5:0] V_IDLE     = 6'b011001;
  localparam logic [5:0] V_IDLE_NR  = 6'b010001;
  localparam logic [5:0] V_WAKE     = 6'b011101;
  localparam logic [5:0] V_RUN_SEC  = 6'b111101;
  localparam logic [5:0] V_RETURN   = 6'b000100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, idle_en = 1'b0, sec_osc_en = 1'b0, sec_osc_run = 1'b0;
  logic pll_sel = 1'b0, wake_evt = 1'b0, tick_alt = 1'b0, phase = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic pri_tick;
  logic cpu_clk_en, per_clk_en, per_src_sec, pri_osc_pwr, pri_ok, sec_active;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) phase <= ~phase;
  assign pri_tick = tick_alt ? phase : 1'b1;

  secclk_pwr_ctrl #(.WAKE_CYC(W), .OST_TICKS(N), .PLL_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_en(idle_en),
    .clk_sel(clk_sel), .sec_osc_en(sec_osc_en), .sec_osc_run(sec_osc_run),
    .pri_tick(pri_tick), .pll_sel(pll_sel), .wake_evt(wake_evt),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .per_src_sec(per_src_sec),
    .pri_osc_pwr(pri_osc_pwr), .pri_ok(pri_ok), .sec_active(sec_active)
  );

  function automatic logic [5:0] outs();
    return {cpu_clk_en, per_src_sec, per_clk_en, pri_osc_pwr, pri_ok, sec_active};
  endfunction

  task automatic chk(input string req, input logic [5:0] exp);
    checks++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, outs(), exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input logic ie, input logic [1:0] sel, input logic se);
    idle_en = ie; clk_sel = sel; sec_osc_en = se;
  endtask

  task automatic try_sleep(input string req, input logic [5:0] exp_next);
    sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    chk(req, exp_next);
  endtask

  task automatic test_reset();
    chk("R10 reset state", V_RUN_PRI);
  endtask

  task automatic test_rejected_sleep();
    set_mode(1'b0, 2'b01, 1'b1); try_sleep("R1 idle_en=0", V_RUN_PRI); step(1); chk("R1 idle_en=0 later", V_RUN_PRI);
    set_mode(1'b1, 2'b10, 1'b1); try_sleep("R1 clk_sel=10", V_RUN_PRI);
    set_mode(1'b1, 2'b00, 1'b1); try_sleep("R1 clk_sel=00", V_RUN_PRI);
    set_mode(1'b1, 2'b01, 1'b0); try_sleep("R2 sec_osc_en=0", V_RUN_PRI); step(1); chk("R2 later", V_RUN_PRI);
  endtask

  task automatic test_wake_in_run();
    wake_evt = 1'b1; step(1); wake_evt = 1'b0;
    chk("R11 wake in primary run", V_RUN_PRI); step(2); chk("R11 later", V_RUN_PRI);
  endtask

  task automatic enter_idle(input logic [5:0] idle_exp);
    set_mode(1'b1, 2'b01, 1'b1);
    try_sleep("R8 entry handover", V_HANDOVER);
    step(1); chk("R3 idle outputs", idle_exp);
  endtask

  // call one cycle after the wake edge has been sampled (in wake wait)
  task automatic finish_return(input logic pll, input int lead);
    int ready_at;
    chk("R5 wake wait, primary powered", V_WAKE);
    step(W - 1); chk("R5 CPU still stopped", V_WAKE);
    step(1); chk("R5 CPU runs on secondary", V_RUN_SEC);
    ready_at = N + (pll ? P : 0);
    step(ready_at - W - lead); chk("R6 still on secondary before ready", V_RUN_SEC);
    step(1); chk("R7 R8 return handover", V_RETURN);
    step(1); chk("R7 primary run restored", V_RUN_PRI);
  endtask

  task automatic test_cycle_no_pll();
    pll_sel = 1'b0; sec_osc_run = 1'b1;
    enter_idle(V_IDLE);
    step(5); chk("R3 idle holds without wake", V_IDLE);
    wake_evt = 1'b1; step(1); wake_evt = 1'b0;
    finish_return(1'b0, 0);
  endtask

  task automatic test_osc_not_running();
    pll_sel = 1'b0; sec_osc_run = 1'b0;
    enter_idle(V_IDLE_NR);
    step(3); chk("R4 peripheral clock withheld", V_IDLE_NR);
    sec_osc_run = 1'b1; #1; chk("R4 peripheral clock after run", V_IDLE);
    step(1);
    wake_evt = 1'b1; step(1); wake_evt = 1'b0;
    finish_return(1'b0, 0);
  endtask

  task automatic test_cycle_pll();
    pll_sel = 1'b1; sec_osc_run = 1'b1;
    enter_idle(V_IDLE);
    wake_evt = 1'b1; step(1); wake_evt = 1'b0;
    finish_return(1'b1, 0);
    pll_sel = 1'b0;
  endtask

  task automatic test_wake_during_entry();
    pll_sel = 1'b0; sec_osc_run = 1'b1;
    set_mode(1'b1, 2'b01, 1'b1);
    try_sleep("R9 entry handover", V_HANDOVER);
    wake_evt = 1'b1; step(1); wake_evt = 1'b0;
    chk("R9 idle with pending wake", V_IDLE);
    step(1);
    finish_return(1'b0, 0);
  endtask

  task automatic test_sparse_ticks();
    pll_sel = 1'b0; sec_osc_run = 1'b1; tick_alt = 1'b1;
    enter_idle(V_IDLE);
    wake_evt = 1'b1; step(1); wake_evt = 1'b0;
    step(N + 1); chk("R6 sparse ticks not ready yet", V_RUN_SEC);
    step(N + 2); chk("R6 sparse ticks primary restored", V_RUN_PRI);
    tick_alt = 1'b0;
  endtask

  initial begin
    step(2); rst_n = 1'b1; step(1);
    test_reset();
    test_rejected_sleep();
    test_wake_in_run();
    test_cycle_no_pll();
    test_osc_not_running();
    test_cycle_pll();
    test_wake_during_entry();
    test_sparse_ticks();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule